// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block is a two-stage SIMD multiplier for 128-bit operands that holds eight 16-bit word lanes. An opcode presented with each operation picks one of two functions. The first is a signed Q15 fractional product that is rounded back to Q15. The second is a byte dot product: within each word lane, the two bytes of A are taken as unsigned and multiplied by the matching signed bytes of B. The two products are added and the sum is clamped into a signed 16-bit word.

The upstream pipeline presents A, B, the opcode and a valid strobe for one cycle. The result leaves the output register exactly two clock edges later, together with its own one-cycle valid strobe. A new operation may be issued every cycle. The output word holds its value between results. Reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `pmul_unit`

## Requirements
- R1: With opcode 0 (fractional), each output word j (bits 16j+15..16j) equals the low 16 bits of floor((a*b + 16384) / 32768), where a and b are the signed 16-bit words of A and B at the same position. Halves are rounded upward, and the result is never simply truncated.
- R2: In fractional mode, the operand pair 0x8000 and 0x8000 gives 0x8000 (the +1.0 result wraps).
- R3: With opcode 1 (byte dot), output word j equals a0*b0 + a1*b1. Here a0 and a1 are the unsigned bytes of A at bits 16j+7..16j and 16j+15..16j+8, and b0 and b1 are the signed bytes of B at those same positions.
- R4: In byte dot mode, a sum above 32767 gives 0x7FFF.
- R5: In byte dot mode, a sum below -32768 gives 0x8000.
- R6: An operation accepted on a rising edge with in_valid high raises out_valid for exactly one cycle, after the second rising edge that follows. Without an accepted operation, out_valid stays low.
- R7: Reset clears out_valid and out_data to zero. Between results, out_data keeps the last result.
- R8: Each word lane is computed only from its own lane of A and B. A different value in one lane does not change any other lane.
- R9: The opcode is captured with its own operation. Back-to-back operations with different opcodes each produce the result of their own opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 = rounded Q15 multiply, 1 = byte dot with saturation |
| in_a | input | 128 | Operand A (8 words / 16 bytes) |
| in_b | input | 128 | Operand B (8 words / 16 bytes) |
| out_valid | output | 1 | Result strobe, two edges after acceptance |
| out_data | output | 128 | Result, eight 16-bit words |

## Verification
A fault in the first-stage registers appears at the ports on the second edge after issue. It shows up as a wrong word in exactly the lane it belongs to, or as the result of the wrong opcode when operations alternate back to back. A stuck or shifted valid bit shows up within two edges as a missing, doubled or early out_valid. Rounding and clamping faults appear only on the operands that hit their edges: the half-LSB product, 0x8000 squared, and the extreme byte sums. For this reason these operands are driven explicitly as well as at random.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int PROD_W = 2 * WORD_W;        // full word product
  localparam int BPROD_W = 2 * BYTE_W + 1;   // unsigned x signed byte product
  localparam int BSUM_W = BPROD_W + 1;       // sum of two byte products

  typedef enum logic {
    OP_Q15 = 1'b0,
    OP_DOT = 1'b1
  } pmul_op_e;
endpackage

// File: rtl/pmul_rst_sync.sv
module pmul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/pmul_q15_lane.sv
module pmul_q15_lane
  import pmul_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [PROD_W-1:0]  prod,
  output logic        [WORD_W-1:0]  res
);
  logic signed [PROD_W-1:0] scaled;

  // keep one guard bit, add half an LSB, then drop the guard bit
  always_comb begin
    scaled = (prod >>> (WORD_W - 2)) + 32'sd1;
    res    = WORD_W'(scaled >>> 1);
  end

  // R2: minus-one squared wraps to 0x8000
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (prod == 32'sh4000_0000) |-> (res == 16'h8000));
endmodule

// File: rtl/pmul_dot_lane.sv
module pmul_dot_lane
  import pmul_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic signed [BPROD_W-1:0] p_lo,
  input  logic signed [BPROD_W-1:0] p_hi,
  output logic        [WORD_W-1:0]  res
);
  localparam logic signed [BSUM_W-1:0] MAX_W = BSUM_W'(32767);
  localparam logic signed [BSUM_W-1:0] MIN_W = -BSUM_W'(32768);

  logic signed [BSUM_W-1:0] sum;

  always_comb begin
    sum = BSUM_W'(p_lo) + BSUM_W'(p_hi);
    if (sum > MAX_W)      res = 16'h7fff;
    else if (sum < MIN_W) res = 16'h8000;
    else                  res = sum[WORD_W-1:0];
  end

  // R4: two non-negative products never produce a negative word
  a_r4_no_neg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (p_lo >= 0 && p_hi >= 0) |-> !res[WORD_W-1]);
  // R5: two negative products always produce a negative word
  a_r5_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (p_lo < 0 && p_hi < 0) |-> res[WORD_W-1]);
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_op,
  input  logic [LANES*WORD_W-1:0]   in_a,
  input  logic [LANES*WORD_W-1:0]   in_b,
  output logic                      out_valid,
  output logic [LANES*WORD_W-1:0]   out_data
);
  localparam int DATA_W = LANES * WORD_W;

  logic rst_sn;

  pmul_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // stage-1 products computed from the inputs
  logic signed [PROD_W-1:0]  mul_w  [LANES];
  logic signed [BPROD_W-1:0] mul_lo [LANES];
  logic signed [BPROD_W-1:0] mul_hi [LANES];

  // stage-1 registers and next state
  logic signed [PROD_W-1:0]  s1_w_q  [LANES];
  logic signed [BPROD_W-1:0] s1_lo_q [LANES];
  logic signed [BPROD_W-1:0] s1_hi_q [LANES];
  logic signed [PROD_W-1:0]  s1_w_d  [LANES];
  logic signed [BPROD_W-1:0] s1_lo_d [LANES];
  logic signed [BPROD_W-1:0] s1_hi_d [LANES];
  pmul_op_e                  s1_op_q, s1_op_d;
  logic                      s1_valid_q;

  // stage-2 lane results and output next state
  logic [WORD_W-1:0] q15_res [LANES];
  logic [WORD_W-1:0] dot_res [LANES];
  logic [DATA_W-1:0] out_d;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [WORD_W-1:0] wa, wb;
    logic signed [BYTE_W:0]   ua_lo, ua_hi;
    logic signed [BYTE_W-1:0] sb_lo, sb_hi;

    assign wa    = in_a[j*WORD_W +: WORD_W];
    assign wb    = in_b[j*WORD_W +: WORD_W];
    assign ua_lo = {1'b0, in_a[j*WORD_W +: BYTE_W]};
    assign ua_hi = {1'b0, in_a[j*WORD_W+BYTE_W +: BYTE_W]};
    assign sb_lo = in_b[j*WORD_W +: BYTE_W];
    assign sb_hi = in_b[j*WORD_W+BYTE_W +: BYTE_W];

    assign mul_w[j]  = PROD_W'(wa) * PROD_W'(wb);
    assign mul_lo[j] = BPROD_W'(ua_lo) * BPROD_W'(sb_lo);
    assign mul_hi[j] = BPROD_W'(ua_hi) * BPROD_W'(sb_hi);

    pmul_q15_lane u_q15 (
      .clk  (clk),
      .rst_n(rst_sn),
      .prod (s1_w_q[j]),
      .res  (q15_res[j])
    );

    pmul_dot_lane u_dot (
      .clk  (clk),
      .rst_n(rst_sn),
      .p_lo (s1_lo_q[j]),
      .p_hi (s1_hi_q[j]),
      .res  (dot_res[j])
    );
  end

  // next state, stage 1
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      s1_w_d[j]  = mul_w[j];
      s1_lo_d[j] = mul_lo[j];
      s1_hi_d[j] = mul_hi[j];
    end
    s1_op_d = pmul_op_e'(in_op);
  end

  // next state, stage 2
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      out_d[j*WORD_W +: WORD_W] = (s1_op_q == OP_DOT) ? dot_res[j] : q15_res[j];
    end
  end

  // stage-1 registers, enabled by in_valid
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int j = 0; j < LANES; j++) begin
        s1_w_q[j]  <= '0;
        s1_lo_q[j] <= '0;
        s1_hi_q[j] <= '0;
      end
      s1_op_q <= OP_Q15;
    end else if (in_valid) begin
      for (int j = 0; j < LANES; j++) begin
        s1_w_q[j]  <= s1_w_d[j];
        s1_lo_q[j] <= s1_lo_d[j];
        s1_hi_q[j] <= s1_hi_d[j];
      end
      s1_op_q <= s1_op_d;
    end
  end

  // stage-2 output register, enabled by stage-1 valid
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)         out_data <= '0;
    else if (s1_valid_q) out_data <= out_d;
  end

  // valid pipeline
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_valid_q <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      s1_valid_q <= in_valid;
      out_valid  <= s1_valid_q;
    end
  end

  // R6: valid advances one stage per edge
  a_r6_issue_to_s1: assert property (@(posedge clk) disable iff (!rst_sn)
    in_valid |=> s1_valid_q);
  a_r6_s1_to_out: assert property (@(posedge clk) disable iff (!rst_sn)
    s1_valid_q |=> out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_sn)
    !s1_valid_q |=> !out_valid);
  // R7: output holds when no result is retiring
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !s1_valid_q |=> $stable(out_data));
endmodule

// File: tb/pmul_unit_bench.sv
module pmul_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_op;
  logic [127:0] in_a, in_b;
  logic         out_valid;
  logic [127:0] out_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pmul_unit u_pmul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [15:0] ref_q15(input logic [15:0] a, input logic [15:0] b);
    longint p, r;
    p = longint'($signed(a)) * longint'($signed(b));
    r = (p + 64'sd16384) >>> 15;
    return r[15:0];
  endfunction

  function automatic logic [15:0] ref_dot(input logic [15:0] a, input logic [15:0] b);
    int s;
    s = int'(a[7:0]) * int'($signed(b[7:0])) + int'(a[15:8]) * int'($signed(b[15:8]));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s[15:0];
  endfunction

  function automatic logic [127:0] ref_vec(input logic op, input logic [127:0] a,
                                           input logic [127:0] b);
    logic [127:0] r;
    for (int j = 0; j < 8; j++)
      r[j*16 +: 16] = op ? ref_dot(a[j*16 +: 16], b[j*16 +: 16])
                         : ref_q15(a[j*16 +: 16], b[j*16 +: 16]);
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one op, verify valid timing and result
  task automatic run_one(input string req, input logic op, input logic [127:0] a,
                         input logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0; in_a = rnd128(); in_b = rnd128(); in_op = ~op;
    check({req, "/R6 early"}, {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    check({req, "/R6 valid"}, {127'd0, out_valid}, 128'd1);
    check(req, out_data, ref_vec(op, a, b));
  endtask

  task automatic t_reset();
    in_valid = 1'b0; in_op = 1'b0; in_a = '0; in_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", {127'd0, out_valid}, 128'd0);
    check("R7 reset data", out_data, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 idle after reset", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_q15_directed();
    run_one("R1 half x half", 1'b0, {8{16'h4000}}, {8{16'h4000}});
    run_one("R1 half x -0.75", 1'b0, {8{16'h4000}}, {8{16'hA000}});
    run_one("R1 round up half lsb", 1'b0, {8{16'h0001}}, {8{16'h4000}});
    run_one("R2 min x min", 1'b0, {8{16'h8000}}, {8{16'h8000}});
  endtask

  task automatic t_dot_directed();
    run_one("R3 A unsigned", 1'b1, {8{16'h0080}}, {8{16'h0001}});
    run_one("R3 B signed", 1'b1, {8{16'h0302}}, {8{16'hFE05}});
    run_one("R4 clamp high", 1'b1, {8{16'hFFFF}}, {8{16'h7F7F}});
    run_one("R5 clamp low", 1'b1, {8{16'hFFFF}}, {8{16'h8080}});
  endtask

  task automatic t_lanes();
    logic [127:0] a, b;
    a = 128'h8000_7FFF_0001_4000_A000_C000_1234_FFFF;
    b = 128'h8000_7FFF_4000_4000_4000_8000_5678_0001;
    run_one("R8 mixed lanes q15", 1'b0, a, b);
    a = 128'hFFFF_0000_80FF_0180_7F01_FFFF_1020_00FF;
    b = 128'h7F7F_7F7F_8080_7F80_FF01_8080_F00F_0080;
    run_one("R8 mixed lanes dot", 1'b1, a, b);
    for (int i = 0; i < 12; i++) run_one("R1 random", 1'b0, rnd128(), rnd128());
    for (int i = 0; i < 12; i++) run_one("R3 random", 1'b1, rnd128(), rnd128());
  endtask

  task automatic t_back_to_back();
    logic [127:0] ea [4];
    logic         op;
    logic [127:0] a, b;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op = i[0]; a = rnd128(); b = rnd128();
      in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
      ea[i] = ref_vec(op, a, b);
      if (i >= 2) begin
        check("R9 b2b valid", {127'd0, out_valid}, 128'd1);
        check("R9 b2b data", out_data, ea[i-2]);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 b2b valid", {127'd0, out_valid}, 128'd1);
    check("R9 b2b data", out_data, ea[2]);
    @(negedge clk);
    check("R9 b2b valid", {127'd0, out_valid}, 128'd1);
    check("R9 b2b data", out_data, ea[3]);
    repeat (3) begin
      @(negedge clk);
      in_a = rnd128(); in_b = rnd128(); in_op = ~in_op;
      check("R7 hold data", out_data, ea[3]);
      check("R6 single pulse", {127'd0, out_valid}, 128'd0);
    end
  endtask

  initial begin
    t_reset();
    t_q15_directed();
    t_dot_directed();
    t_lanes();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule